// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block recovers characters from an asynchronous serial line. It resynchronises the raw line, finds the falling edge of a start bit and confirms it half a bit later. It then samples each following bit at its centre, using a tick that arrives sixteen times per bit period. A character has seven or eight data bits, least significant first. An optional parity bit and one or two stop bits follow.

When the character completes, three checks run: parity, stop bit and whether the previous character is still unread. A character that passes all three is placed in the data register and raises the full flag. A character that fails any check sets the matching sticky flag and is never written to the data register. While any error flag is set, the receiver ignores the line. It starts again only after software has cleared every error flag. Two interrupt outputs, one for data and one for errors, share a single enable.

Top module: `async_rx_unit`

## Requirements
- R1: After reset the data register reads 0, the full flag and the overrun, parity and framing flags are 0, both interrupt outputs are 0, and the receiver is waiting for a start bit.
- R2: In 8-bit mode a clean character is assembled least significant bit first. It is loaded into `rdata_o` and `full_o` goes to 1.
- R3: In 7-bit mode (`cfg_eight_i`=0) seven data bits are received. `rdata_o` bit 7 reads 0.
- R4: With parity enabled, the parity bit follows the last data bit. With `cfg_par_odd_i`=0 the data ones plus the parity bit must be even; with `cfg_par_odd_i`=1 they must be odd. A mismatch sets `par_o`, and the character is not loaded.
- R5: A 0 in the first stop bit sets `frm_o`, and the character is not loaded. With `cfg_two_stop_i`=1 the second stop bit is not checked.
- R6: If `full_o` is 1 when a character completes, `ovr_o` is set, `rdata_o` keeps the old character and `full_o` stays 1.
- R7: While any of `ovr_o`, `par_o`, `frm_o` is 1, start bits are ignored and no flag or data changes.
- R8: A one-cycle `rd_i` pulse clears `full_o`. Each of `clr_ovr_i`, `clr_par_i`, `clr_frm_i` clears its own flag. Error flags otherwise stay set.
- R9: `irq_rx_o` is 1 exactly when `irq_en_i` and `full_o` are both 1. `irq_err_o` is 1 exactly when `irq_en_i` is 1 and any error flag is 1.
- R10: A low pulse shorter than half a bit period on an idle line is rejected as a glitch and produces no character.
- R11: The framing inputs are taken only when a start bit is detected. Changing them during a character does not change how that character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial input, idle high |
| os_tick_i | input | 1 | One-cycle tick at 16 times the bit rate |
| cfg_eight_i | input | 1 | 1 for 8 data bits, 0 for 7 |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_odd_i | input | 1 | 1 for odd parity, 0 for even |
| cfg_two_stop_i | input | 1 | Two stop bits |
| irq_en_i | input | 1 | Shared interrupt enable |
| rd_i | input | 1 | Data register read strobe |
| clr_ovr_i | input | 1 | Clear overrun flag |
| clr_par_i | input | 1 | Clear parity flag |
| clr_frm_i | input | 1 | Clear framing flag |
| rdata_o | output | DATA_W | Received data register |
| full_o | output | 1 | Data register holds an unread character |
| ovr_o | output | 1 | Overrun error flag |
| par_o | output | 1 | Parity error flag |
| frm_o | output | 1 | Framing error flag |
| irq_rx_o | output | 1 | Receive data interrupt |
| irq_err_o | output | 1 | Receive error interrupt |

## Verification
The bench uses the default parameters, DATA_W of 8 and an oversampling ratio of 16. It runs the tick at one pulse every four clocks, so a bit lasts 64 clocks. With these values both the 8-bit and the truncated 7-bit data paths are exercised, along with both parity senses and the second-stop-bit window. The 64-clock bit also leaves room for a glitch of a few ticks to fall well inside the half-bit confirmation window.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_cfg_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import async_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  rx_cfg_t           cfg_i,
    input  logic              hold_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bad_o,
    output logic              stop_bad_o
);
    localparam int CW   = $clog2(OSR);
    localparam int BW   = $clog2(DATA_W + 1);
    localparam int HALF = OSR / 2 - 1;

    typedef struct packed {
        rx_state_e         state;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     bits;
        logic [DATA_W-1:0] shreg;
        rx_cfg_t           cfg;
        logic              pbit;
        logic              done;
        logic [DATA_W-1:0] data;
        logic              par_bad;
        logic              stop_bad;
    } eng_t;

    eng_t q, d;
    logic              last;
    logic [BW-1:0]     nbits;
    logic [DATA_W-1:0] aligned;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        last    = (q.cnt == CW'(OSR - 1));
        nbits   = q.cfg.eight ? BW'(DATA_W) : BW'(DATA_W - 1);
        aligned = q.cfg.eight ? q.shreg : {1'b0, q.shreg[DATA_W-1:1]};
        case (q.state)
            ST_IDLE: begin
                if (tick_i && !rx_i && !hold_i) begin
                    d.state = ST_START;
                    d.cnt   = '0;
                    d.cfg   = cfg_i;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (q.cnt == CW'(HALF)) begin
                        d.cnt   = '0;
                        d.bits  = '0;
                        d.state = rx_i ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (last) begin
                        d.cnt   = '0;
                        d.shreg = {rx_i, q.shreg[DATA_W-1:1]};
                        d.bits  = q.bits + 1'b1;
                        if (d.bits == nbits)
                            d.state = q.cfg.par_en ? ST_PAR : ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    if (last) begin
                        d.cnt   = '0;
                        d.pbit  = rx_i;
                        d.state = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (last) begin
                        d.cnt      = '0;
                        d.done     = 1'b1;
                        d.data     = aligned;
                        d.stop_bad = !rx_i;
                        d.par_bad  = q.cfg.par_en &&
                                     ((^aligned ^ q.pbit) != q.cfg.par_odd);
                        d.state    = q.cfg.two_stop ? ST_STOP2 : ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP2: begin
                if (tick_i) begin
                    if (last) begin
                        d.cnt   = '0;
                        d.state = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o     = q.done;
    assign data_o     = q.data;
    assign par_bad_o  = q.par_bad;
    assign stop_bad_o = q.stop_bad;
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_bad_i,
    input  logic              stop_bad_i,
    input  logic              rd_i,
    input  logic              clr_ovr_i,
    input  logic              clr_par_i,
    input  logic              clr_frm_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              par_o,
    output logic              frm_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              full;
        logic              ovr;
        logic              par;
        logic              frm;
    } stat_t;

    stat_t q, d;

    always_comb begin
        d = q;
        if (rd_i)      d.full = 1'b0;
        if (clr_ovr_i) d.ovr  = 1'b0;
        if (clr_par_i) d.par  = 1'b0;
        if (clr_frm_i) d.frm  = 1'b0;
        if (done_i) begin
            if (stop_bad_i) d.frm = 1'b1;
            if (par_bad_i)  d.par = 1'b1;
            if (q.full)     d.ovr = 1'b1;
            if (!stop_bad_i && !par_bad_i && !q.full) begin
                d.rdata = data_i;
                d.full  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata_o = q.rdata;
    assign full_o  = q.full;
    assign ovr_o   = q.ovr;
    assign par_o   = q.par;
    assign frm_o   = q.frm;
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit
    import async_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              os_tick_i,
    input  logic              cfg_eight_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_odd_i,
    input  logic              cfg_two_stop_i,
    input  logic              irq_en_i,
    input  logic              rd_i,
    input  logic              clr_ovr_i,
    input  logic              clr_par_i,
    input  logic              clr_frm_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              par_o,
    output logic              frm_o,
    output logic              irq_rx_o,
    output logic              irq_err_o
);
    logic              rx_s;
    logic              err_any;
    logic              done;
    logic [DATA_W-1:0] frame_data;
    logic              par_bad;
    logic              stop_bad;
    rx_cfg_t           cfg;

    assign cfg = '{eight: cfg_eight_i, par_en: cfg_par_en_i,
                   par_odd: cfg_par_odd_i, two_stop: cfg_two_stop_i};

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    rx_frame_engine #(.OSR(OSR), .DATA_W(DATA_W)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (os_tick_i),
        .rx_i       (rx_s),
        .cfg_i      (cfg),
        .hold_i     (err_any),
        .done_o     (done),
        .data_o     (frame_data),
        .par_bad_o  (par_bad),
        .stop_bad_o (stop_bad)
    );

    rx_status_regs #(.DATA_W(DATA_W)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .data_i     (frame_data),
        .par_bad_i  (par_bad),
        .stop_bad_i (stop_bad),
        .rd_i       (rd_i),
        .clr_ovr_i  (clr_ovr_i),
        .clr_par_i  (clr_par_i),
        .clr_frm_i  (clr_frm_i),
        .rdata_o    (rdata_o),
        .full_o     (full_o),
        .ovr_o      (ovr_o),
        .par_o      (par_o),
        .frm_o      (frm_o)
    );

    assign err_any   = ovr_o | par_o | frm_o;
    assign irq_rx_o  = irq_en_i & full_o;
    assign irq_err_o = irq_en_i & err_any;
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_i,
    input logic              clr_ovr_i,
    input logic              clr_par_i,
    input logic              clr_frm_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              full_o,
    input logic              ovr_o,
    input logic              par_o,
    input logic              frm_o
);
    // R2
    full_rise_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> !(ovr_o || par_o || frm_o));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(full_o) |-> $stable(rdata_o));

    // R6
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $past(full_o));

    // R8
    full_fall_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_o) |-> $past(rd_i));

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !clr_ovr_i) |=> ovr_o);

    // R8
    par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_o && !clr_par_i) |=> par_o);

    // R8
    frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_o && !clr_frm_i) |=> frm_o);
endmodule

bind async_rx_unit async_rx_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (rd_i),
    .clr_ovr_i (clr_ovr_i),
    .clr_par_i (clr_par_i),
    .clr_frm_i (clr_frm_i),
    .rdata_o   (rdata_o),
    .full_o    (full_o),
    .ovr_o     (ovr_o),
    .par_o     (par_o),
    .frm_o     (frm_o)
);

// File: tb/test_async_rx_unit.sv
module test_async_rx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       irq_en = 1'b1;
    logic       rd = 1'b0, clr_ovr = 1'b0, clr_par = 1'b0, clr_frm = 1'b0;
    logic [7:0] rdata;
    logic       full, ovr, par, frm, irq_rx, irq_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int tdiv = 0;
    bit quiet = 1'b0;

    logic [7:0] m_rdata = 8'h00;
    bit m_full = 0, m_ovr = 0, m_par = 0, m_frm = 0;

    localparam int BITCLK = 64;

    always #2 clk = ~clk;

    async_rx_unit i_async_rx_unit (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .os_tick_i(tick),
        .cfg_eight_i(cfg_eight), .cfg_par_en_i(cfg_par_en),
        .cfg_par_odd_i(cfg_par_odd), .cfg_two_stop_i(cfg_two_stop),
        .irq_en_i(irq_en), .rd_i(rd), .clr_ovr_i(clr_ovr),
        .clr_par_i(clr_par), .clr_frm_i(clr_frm),
        .rdata_o(rdata), .full_o(full), .ovr_o(ovr), .par_o(par),
        .frm_o(frm), .irq_rx_o(irq_rx), .irq_err_o(irq_err)
    );

    always @(negedge clk) begin
        tick = (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "rdata", rdata, m_rdata);
        check(req, "full", full, m_full);
        check(req, "ovr", ovr, m_ovr);
        check(req, "par", par, m_par);
        check(req, "frm", frm, m_frm);
        check("R9", "irq_rx", irq_rx, irq_en & m_full);
        check("R9", "irq_err", irq_err, irq_en & (m_ovr | m_par | m_frm));
    endtask

    always @(posedge clk) begin
        #1;
        if (quiet) compare_all("R7");
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic drive_bit(input logic v);
        rx = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic settle();
        quiet = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] dat, input bit eight, input bit pen,
                             input bit podd, input bit flip_par, input bit bad_stop,
                             input bit two_stop, input bit bad_stop2, input bit flip_cfg);
        logic [7:0] v;
        logic       pb;
        quiet = 1'b0;
        v = eight ? dat : {1'b0, dat[6:0]};
        cfg_eight = eight; cfg_par_en = pen; cfg_par_odd = podd; cfg_two_stop = two_stop;
        drive_bit(1'b0);
        if (flip_cfg) begin
            cfg_eight = ~eight; cfg_par_en = ~pen; cfg_two_stop = ~two_stop;
        end
        for (int i = 0; i < (eight ? 8 : 7); i++) drive_bit(v[i]);
        if (pen) begin
            pb = (^v) ^ podd ^ flip_par;
            drive_bit(pb);
        end
        drive_bit(!bad_stop);
        if (two_stop) drive_bit(!bad_stop2);
        rx = 1'b1;
        repeat (48) @(negedge clk);
        cfg_eight = eight; cfg_par_en = pen; cfg_two_stop = two_stop;
        if (!(m_ovr || m_par || m_frm)) begin
            if (bad_stop) m_frm = 1;
            if (pen && flip_par) m_par = 1;
            if (m_full) m_ovr = 1;
            else if (!bad_stop && !(pen && flip_par)) begin
                m_rdata = v;
                m_full  = 1;
            end
        end
        settle();
    endtask

    task automatic do_read();
        quiet = 1'b0;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        m_full = 0;
        @(negedge clk);
        settle();
    endtask

    task automatic do_clear(input bit o, input bit p, input bit f);
        quiet = 1'b0;
        clr_ovr = o; clr_par = p; clr_frm = f;
        @(negedge clk);
        clr_ovr = 1'b0; clr_par = 1'b0; clr_frm = 1'b0;
        if (o) m_ovr = 0;
        if (p) m_par = 0;
        if (f) m_frm = 0;
        @(negedge clk);
        settle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        compare_all("R1");
        settle();

        // R2 clean 8-bit character, LSB first
        send_char(8'hA5, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R2", "loaded data", rdata, 8'hA5);
        check("R9", "data irq", irq_rx, 1'b1);
        do_read();
        check("R8", "full after read", full, 1'b0);

        // R3 and R4: 7-bit even parity, good parity
        send_char(8'hB5, 0, 1, 0, 0, 0, 0, 0, 0);
        check("R3", "7-bit data", rdata, 8'h35);
        do_read();

        // R4 odd parity accepted
        send_char(8'h3C, 1, 1, 1, 0, 0, 0, 0, 0);
        check("R4", "odd parity data", rdata, 8'h3C);

        // R6 overrun: unread 0x3C, second character arrives
        send_char(8'h11, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R6", "ovr set", ovr, 1'b1);
        check("R6", "data kept", rdata, 8'h3C);
        check("R9", "err irq", irq_err, 1'b1);

        // R7 character ignored while an error flag is set
        do_read();
        send_char(8'h77, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R7", "no load while error", full, 1'b0);
        check("R7", "data unchanged", rdata, 8'h3C);
        do_clear(1, 0, 0);
        check("R8", "ovr cleared", ovr, 1'b0);

        // R4 parity error (even parity, wrong bit)
        send_char(8'h5A, 1, 1, 0, 1, 0, 0, 0, 0);
        check("R4", "par set", par, 1'b1);
        check("R4", "no load on parity error", full, 1'b0);
        do_clear(0, 1, 0);

        // R5 framing error
        send_char(8'hC3, 1, 0, 0, 0, 1, 0, 0, 0);
        check("R5", "frm set", frm, 1'b1);
        check("R5", "no load on framing error", full, 1'b0);
        do_clear(0, 0, 1);

        // R5 two stop bits, second stop low is not checked
        send_char(8'h96, 1, 0, 0, 0, 0, 1, 1, 0);
        check("R5", "second stop ignored", frm, 1'b0);
        check("R5", "loaded with two stops", rdata, 8'h96);
        do_read();

        // R10 glitch shorter than half a bit
        quiet = 1'b0;
        rx = 1'b0;
        repeat (8) @(negedge clk);
        rx = 1'b1;
        repeat (BITCLK * 12) @(negedge clk);
        settle();
        check("R10", "glitch gives no char", full, 1'b0);

        // R11 framing inputs changed mid-character
        send_char(8'hE7, 1, 0, 0, 0, 0, 0, 0, 1);
        check("R11", "cfg taken at start", rdata, 8'hE7);
        check("R11", "no error from cfg change", frm | par, 1'b0);

        // R9 interrupts disabled
        quiet = 1'b0;
        irq_en = 1'b0;
        @(negedge clk);
        settle();
        check("R9", "data irq masked", irq_rx, 1'b0);
        do_read();

        quiet = 1'b0;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule